// File: doc/BRIEF.md
# RTC Tick Counter with Alarm

This block is a real-time-clock core behind a byte-wide register bus. A 40-bit tick counter is advanced from an external 32.768 kHz clock-enable strobe. A divide-by-32 prescaler gives 1024 ticks per second, so whole seconds are the count shifted right by ten. A control bit bypasses the prescaler, and then every strobe is a tick. A 24-bit alarm register is compared with the low bits of the count, which gives a look-ahead of about 2^14 seconds. A match raises a sticky flag that drives the interrupt output.

A host reads the time in two steps. It first reads the trigger address. That read copies the whole live count into a snapshot, and the five count-byte addresses then return this frozen copy. To set the time, the host clears the run bit and writes the five count bytes, most significant first. The first four bytes wait in a holding register. Writing the least significant byte moves all 40 bits into the counter in one cycle. The host then sets the run bit again.

Top module: `rtc_tick_core`

## Requirements
- R1: After reset the count and alarm value are zero, the control register reads 0x80 (power-on flag set, all other bits clear), the status register reads 0x00 and `alarm_irq` is low.
- R2: With the run bit (control bit 5) set and prescaler bypass (control bit 3) set, each `osc_step_en` pulse advances the count by one.
- R3: With run set and bypass clear, the count advances once per 32 `osc_step_en` pulses. Prescaler phase restarts at zero whenever run is clear or the count is loaded.
- R4: While the run bit is clear, strobes do not change the count and cannot set the alarm flag.
- R5: A read of address 0xC5 copies the live count into the snapshot. Reads of 0xC6 (bits 39:32) through 0xCA (bits 7:0) return snapshot bytes, which stay unchanged while counting goes on until the next read of 0xC5.
- R6: Writes to 0xC6..0xC9 go to a holding register and leave the counter unchanged. A write to 0xCA loads {held bytes, written byte} into the counter.
- R7: The alarm value sits at 0xC1 (bits 23:16) through 0xC3 (bits 7:0). When a tick makes the low 24 count bits equal the alarm value, status bit 0 at 0xC4 sets and `alarm_irq` goes high at the same clock edge.
- R8: The alarm flag and `alarm_irq` stay set until the host writes 0xC4 with bit 0 = 1. A write with bit 0 = 0 has no effect.
- R9: Count bits 39:24 take no part in the alarm compare.
- R10: The count wraps from all ones to zero and raises no flag of its own.
- R11: Control bits 6:1 are read/write storage and bit 0 reads 0. Bit 7 (power-on flag) is cleared by writing 0; writing 1 does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_step_en | input | 1 | One-cycle strobe at the 32.768 kHz oscillator rate |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, applied at the clock edge |
| bus_rd | input | 1 | Read strobe; a read of 0xC5 latches the snapshot at the edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from registers, zero when not reading |
| alarm_irq | output | 1 | Sticky alarm interrupt |

## Verification
A fault in the prescaler shows as a count that is off after 32 strobes in prescaled mode, or after a single strobe in bypass mode. A corrupted holding register or snapshot shows in the next five-byte read, and a broken snapshot also shows as bytes that drift while ticks arrive between reads. A wrong alarm compare shows on `alarm_irq` at the exact strobe that reaches the match: one strobe early, late, or never. Upper count bits that are set differently from the alarm must not hide the match. A flag that does not stay set shows as the interrupt falling before the clearing write.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

    // Control register image, bit 7 down to bit 1 (bit 0 reads zero)
    typedef struct packed {
        logic       por;      // power-on indicator
        logic       osc_sel;  // oscillator source select (stored only)
        logic       run;      // counting and alarm armed
        logic       buf_en;   // clock output buffer enable (stored only)
        logic       bypass;   // prescaler bypass
        logic [1:0] cap_sel;  // load capacitance select (stored only)
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{por: 1'b1, default: '0};

    function automatic logic [7:0] ctrl_to_byte(ctrl_t c);
        return {c, 1'b0};
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bypass,
    input  logic step_en,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        tick    = run && step_en && (bypass || phase_q == LAST);
        if (!run || restart) begin
            phase_d = '0;
        end else if (step_en && !bypass) begin
            phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/rtc_counter.sv
`timescale 1ns/1ps
module rtc_counter #(
    parameter int CNT_W = 40,
    localparam int NB    = CNT_W / 8,
    localparam int IDX_W = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             snap_req,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] count_nx_o,
    output logic [CNT_W-1:0] snap_o,
    output logic             load_o,
    output logic             advance_o
);
    localparam int STG_W = CNT_W - 8;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [STG_W-1:0] stage;
        logic [CNT_W-1:0] snap;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    load, advance;

    always_comb begin
        st_d    = st_q;
        load    = wr_en && (wr_idx == IDX_W'(NB - 1));
        advance = tick && !load;
        if (wr_en && !load) begin
            for (int i = 0; i < NB - 1; i++) begin
                if (wr_idx == IDX_W'(i)) st_d.stage[(NB-2-i)*8 +: 8] = wr_data;
            end
        end
        if (load)         st_d.count = {st_q.stage, wr_data};
        else if (advance) st_d.count = st_q.count + 1'b1;
        if (snap_req)     st_d.snap  = st_q.count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o    = st_q.count;
    assign count_nx_o = st_d.count;
    assign snap_o     = st_q.snap;
    assign load_o     = load;
    assign advance_o  = advance;
endmodule

// File: rtl/rtc_alarm.sv
`timescale 1ns/1ps
module rtc_alarm #(
    parameter int ALM_W = 24,
    localparam int AB   = ALM_W / 8,
    localparam int AIDX_W = (AB > 1) ? $clog2(AB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AIDX_W-1:0] wr_idx,
    input  logic [7:0]        wr_data,
    input  logic              advance,
    input  logic [ALM_W-1:0]  count_nx_low,
    input  logic              clr,
    output logic [ALM_W-1:0]  alarm_o,
    output logic              flag_o
);
    typedef struct packed {
        logic [ALM_W-1:0] alarm;
        logic             flag;
    } alm_st_t;

    alm_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d = st_q;
        hit  = advance && (count_nx_low == st_q.alarm);
        if (wr_en) begin
            for (int i = 0; i < AB; i++) begin
                if (wr_idx == AIDX_W'(i)) st_d.alarm[(AB-1-i)*8 +: 8] = wr_data;
            end
        end
        if (hit)      st_d.flag = 1'b1;
        else if (clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alarm_o = st_q.alarm;
    assign flag_o  = st_q.flag;
endmodule

// File: rtl/rtc_tick_core.sv
`timescale 1ns/1ps
module rtc_tick_core
    import rtc_pkg::*;
#(
    parameter int          CNT_W     = 40,
    parameter int          ALM_W     = 24,
    parameter int          PRESC_DIV = 32,
    parameter logic [7:0]  BASE_ADDR = 8'hC0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_step_en,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       alarm_irq
);
    localparam int NB     = CNT_W / 8;
    localparam int AB     = ALM_W / 8;
    localparam int IDX_W  = $clog2(NB);
    localparam int AIDX_W = (AB > 1) ? $clog2(AB) : 1;
    localparam logic [7:0] CTRL_A = BASE_ADDR;
    localparam logic [7:0] ALM_A  = BASE_ADDR + 8'd1;
    localparam logic [7:0] STAT_A = BASE_ADDR + 8'(AB + 1);
    localparam logic [7:0] SNAP_A = BASE_ADDR + 8'(AB + 2);
    localparam logic [7:0] CNT_A  = BASE_ADDR + 8'(AB + 3);

    typedef struct packed {
        ctrl_t ctrl;
    } top_st_t;

    top_st_t st_d, st_q;

    logic             ctrl_run, tick_w, load_w, advance_w, flag_w;
    logic             cnt_sel, alm_sel, snap_req, flag_clr;
    logic [7:0]       cnt_off, alm_off;
    logic [CNT_W-1:0] count_w, count_nx_w, snap_w;
    logic [ALM_W-1:0] alarm_w;

    // address decode
    always_comb begin
        cnt_off  = bus_addr - CNT_A;
        alm_off  = bus_addr - ALM_A;
        cnt_sel  = (bus_addr >= CNT_A) && (cnt_off < 8'(NB));
        alm_sel  = (bus_addr >= ALM_A) && (alm_off < 8'(AB));
        snap_req = bus_rd && (bus_addr == SNAP_A);
        flag_clr = bus_wr && (bus_addr == STAT_A) && bus_wdata[0];
    end

    // control register
    always_comb begin
        st_d = st_q;
        if (bus_wr && bus_addr == CTRL_A) begin
            st_d.ctrl.por     = st_q.ctrl.por & bus_wdata[7];
            st_d.ctrl.osc_sel = bus_wdata[6];
            st_d.ctrl.run     = bus_wdata[5];
            st_d.ctrl.buf_en  = bus_wdata[4];
            st_d.ctrl.bypass  = bus_wdata[3];
            st_d.ctrl.cap_sel = bus_wdata[2:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ctrl: CTRL_RESET};
        else        st_q <= st_d;
    end

    assign ctrl_run = st_q.ctrl.run;

    rtc_prescaler #(.DIV(PRESC_DIV)) i_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_run),
        .bypass  (st_q.ctrl.bypass),
        .step_en (osc_step_en),
        .restart (load_w),
        .tick    (tick_w)
    );

    rtc_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_w),
        .wr_en      (bus_wr && cnt_sel),
        .wr_idx     (cnt_off[IDX_W-1:0]),
        .wr_data    (bus_wdata),
        .snap_req   (snap_req),
        .count_o    (count_w),
        .count_nx_o (count_nx_w),
        .snap_o     (snap_w),
        .load_o     (load_w),
        .advance_o  (advance_w)
    );

    rtc_alarm #(.ALM_W(ALM_W)) i_alm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (bus_wr && alm_sel),
        .wr_idx       (alm_off[AIDX_W-1:0]),
        .wr_data      (bus_wdata),
        .advance      (advance_w),
        .count_nx_low (count_nx_w[ALM_W-1:0]),
        .clr          (flag_clr),
        .alarm_o      (alarm_w),
        .flag_o       (flag_w)
    );

    // read mux
    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd) begin
            if (bus_addr == CTRL_A) bus_rdata = ctrl_to_byte(st_q.ctrl);
            if (bus_addr == STAT_A) bus_rdata = {7'b0, flag_w};
            for (int i = 0; i < AB; i++) begin
                if (bus_addr == ALM_A + 8'(i)) bus_rdata = alarm_w[(AB-1-i)*8 +: 8];
            end
            for (int i = 0; i < NB; i++) begin
                if (bus_addr == CNT_A + 8'(i)) bus_rdata = snap_w[(NB-1-i)*8 +: 8];
            end
        end
    end

    assign alarm_irq = flag_w;
endmodule

// File: rtl/rtc_tick_core_chk.sv
`timescale 1ns/1ps
module rtc_tick_core_chk #(
    parameter int         CNT_W     = 40,
    parameter logic [7:0] BASE_ADDR = 8'hC0,
    parameter int         ALM_W     = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [7:0]       bus_wdata,
    input logic             alarm_irq,
    input logic             run,
    input logic             tick,
    input logic             load,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] snap
);
    localparam logic [7:0] STAT_A = BASE_ADDR + 8'(ALM_W / 8 + 1);
    localparam logic [7:0] SNAP_A = BASE_ADDR + 8'(ALM_W / 8 + 2);

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq && !(bus_wr && bus_addr == STAT_A && bus_wdata[0]) |=> alarm_irq);

    // R5
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == SNAP_A) |=> $stable(snap));

    // R4
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !load |=> $stable(count));

    // R10
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&count) && tick && !load |=> count == '0);

    // R2
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load |=> count == $past(count) + 1'b1);

    // R7
    irq_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> $past(run));
endmodule

bind rtc_tick_core rtc_tick_core_chk #(
    .CNT_W(CNT_W), .BASE_ADDR(BASE_ADDR), .ALM_W(ALM_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .alarm_irq (alarm_irq),
    .run       (ctrl_run),
    .tick      (tick_w),
    .load      (load_w),
    .count     (count_w),
    .snap      (snap_w)
);

// File: tb/test_rtc_tick_core.sv
`timescale 1ns/1ps
module test_rtc_tick_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_step_en = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       alarm_irq;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    localparam logic [7:0] A_CTRL = 8'hC0, A_ALM = 8'hC1, A_STAT = 8'hC4,
                           A_SNAP = 8'hC5, A_CNT = 8'hC6;

    always #10 clk = ~clk;

    rtc_tick_core i_rtc_tick_core (
        .clk(clk), .rst_n(rst_n), .osc_step_en(osc_step_en),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); osc_step_en = 1'b1;
            @(negedge clk); osc_step_en = 1'b0;
        end
    endtask

    task automatic read_bytes(output logic [39:0] v);
        logic [7:0] b;
        v = '0;
        for (int i = 0; i < 5; i++) begin
            bus_read(A_CNT + 8'(i), b);
            v = {v[31:0], b};
        end
    endtask

    task automatic read_count(output logic [39:0] v);
        logic [7:0] b;
        bus_read(A_SNAP, b);
        read_bytes(v);
    endtask

    task automatic write_count(input logic [39:0] v);
        for (int i = 0; i < 5; i++) bus_write(A_CNT + 8'(i), v[(4-i)*8 +: 8]);
    endtask

    task automatic write_alarm(input logic [23:0] v);
        for (int i = 0; i < 3; i++) bus_write(A_ALM + 8'(i), v[(2-i)*8 +: 8]);
    endtask

    task automatic t_reset();
        logic [7:0] b; logic [39:0] v;
        bus_read(A_CTRL, b); chk("R1 ctrl", b, 8'h80);
        bus_read(A_STAT, b); chk("R1 status", b, 8'h00);
        chk("R1 irq", alarm_irq, 1'b0);
        read_count(v);       chk("R1 count", v, 40'h0);
        for (int i = 0; i < 3; i++) begin
            bus_read(A_ALM + 8'(i), b); chk("R1 alarm byte", b, 8'h00);
        end
    endtask

    task automatic t_ctrl();
        logic [7:0] b;
        bus_write(A_CTRL, 8'h7F);
        bus_read(A_CTRL, b); chk("R11 por cleared, bit0 zero", b, 8'h7E);
        bus_write(A_CTRL, 8'h80);
        bus_read(A_CTRL, b); chk("R11 por not set by 1", b, 8'h00);
    endtask

    task automatic t_bypass();
        logic [39:0] v;
        bus_write(A_CTRL, 8'h28);
        pulses(10);
        read_count(v); chk("R2 bypass count", v, 40'd10);
    endtask

    task automatic t_stopped();
        logic [39:0] v;
        bus_write(A_CTRL, 8'h08);
        pulses(5);
        read_count(v); chk("R4 held while stopped", v, 40'd10);
        chk("R4 no irq", alarm_irq, 1'b0);
    endtask

    task automatic t_prescale();
        logic [39:0] v;
        write_count(40'h0);
        bus_write(A_CTRL, 8'h20);
        pulses(31);
        read_count(v); chk("R3 31 strobes", v, 40'd0);
        pulses(1);
        read_count(v); chk("R3 32 strobes", v, 40'd1);
        pulses(64);
        read_count(v); chk("R3 96 strobes", v, 40'd3);
    endtask

    task automatic t_load();
        logic [39:0] v;
        bus_write(A_CTRL, 8'h00);
        bus_write(A_CNT + 8'd0, 8'h12);
        bus_write(A_CNT + 8'd1, 8'h34);
        bus_write(A_CNT + 8'd2, 8'h56);
        bus_write(A_CNT + 8'd3, 8'h78);
        read_count(v); chk("R6 staged bytes not yet live", v, 40'd3);
        bus_write(A_CNT + 8'd4, 8'h9A);
        read_count(v); chk("R6 loaded on low byte", v, 40'h123456789A);
    endtask

    task automatic t_snapshot();
        logic [7:0] b; logic [39:0] v;
        bus_write(A_CTRL, 8'h28);
        bus_read(A_SNAP, b);
        pulses(4);
        read_bytes(v); chk("R5 snapshot frozen", v, 40'h123456789A);
        read_count(v); chk("R5 snapshot refreshed", v, 40'h123456789E);
    endtask

    task automatic t_alarm();
        logic [7:0] b;
        bus_write(A_CTRL, 8'h00);
        write_count(40'hAB0000FFFC);
        write_alarm(24'h010000);
        bus_write(A_CTRL, 8'h28);
        pulses(3);
        chk("R7 no early irq", alarm_irq, 1'b0);
        pulses(1);
        chk("R9 match despite upper bits", alarm_irq, 1'b1);
        bus_read(A_STAT, b); chk("R7 status flag", b, 8'h01);
        pulses(5);
        chk("R8 irq held", alarm_irq, 1'b1);
        bus_write(A_STAT, 8'h00);
        chk("R8 write 0 ignored", alarm_irq, 1'b1);
        bus_write(A_STAT, 8'h01);
        chk("R8 cleared", alarm_irq, 1'b0);
    endtask

    task automatic t_wrap();
        logic [39:0] v;
        bus_write(A_CTRL, 8'h00);
        write_count(40'hFFFFFFFFFE);
        write_alarm(24'h800000);
        bus_write(A_CTRL, 8'h28);
        pulses(2);
        read_count(v); chk("R10 wrapped", v, 40'h0);
        chk("R10 no flag", alarm_irq, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_bypass();
        t_stopped();
        t_prescale();
        t_load();
        t_snapshot();
        t_alarm();
        t_wrap();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule